// File: doc/BRIEF.md
# Debug Port Register Read Sequencer

This block sits behind a serial debug port and interprets the 16-bit words that arrive on each completed shift. A word is offered on `shift_word` with a one-cycle `shift_valid` pulse. In the same cycle the host takes the 17-bit response held on `resp_status`/`resp_word`, so every response answers an earlier shift. Two commands are understood: a control-register read and a forced termination of a stuck internal bus cycle. Any other opcode is answered as illegal.

A register read is three shifted words: the opcode, then the upper and the lower address halves. The sequencer then raises a request on a plain request/acknowledge port and keeps it up until the port acknowledges or signals an error. While the address is being gathered and while the read is outstanding, each shift returns not-ready. An acknowledge makes the next two shifts return the 32-bit value, upper half first. An error makes the next shift return the bus-error code instead. The force command pulses `force_ack` toward the internal bus. It also cancels any outstanding read, and that read then reports a bus error.

Response codes as {status, data}: not-ready is {1, 0x0000}, bus error and illegal command are both {1, 0x0001}, command complete is {0, 0xFFFF}, and result data is {0, value}.

Top module: `dbg_rdseq`

## Requirements
- R1: After reset the held response is not-ready {1, 0x0000}, and `bus_req` and `force_ack` are low.
- R2: The opcode 0x2980 starts a register read. The next two shifted words are taken as the upper and the lower halves of `bus_addr`. `bus_req` rises in the cycle after the third word, and `bus_addr` stays stable while `bus_req` is high.
- R3: The shifts that follow the opcode word and each address word return not-ready. So does every shift while `bus_req` is high. A word other than the force opcode shifted in while the read is outstanding is ignored.
- R4: After an acknowledge, the next shift returns {0, rdata[31:16]} and the one after returns {0, rdata[15:0]}. The word shifted with the upper half is ignored.
- R5: `bus_req` stays high until `bus_ack` or `bus_berr` is seen, and falls in the following cycle.
- R6: After `bus_berr` the next shift returns {1, 0x0001}, and the word shifted with that response is decoded as a new command.
- R7: The force opcode 0x00C0, sent while idle, makes the next shift return {0, 0xFFFF}. `force_ack` is high for exactly the one cycle after that shift.
- R8: The force opcode sent while a read is outstanding drops `bus_req` and pulses `force_ack`. The next shift returns {1, 0x0001}, and the shift after that returns {0, 0xFFFF}.
- R9: Any other opcode sent while idle makes the next shift return {1, 0x0001}, and the sequencer stays idle.
- R10: The word shifted with the lower result half is decoded as a new command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| shift_valid | input | 1 | One-cycle pulse: a shift completed |
| shift_word | input | 16 | Word received on this shift |
| resp_status | output | 1 | Status bit of the response for the next shift |
| resp_word | output | 16 | Data of the response for the next shift |
| bus_req | output | 1 | Internal control-register read request |
| bus_addr | output | 32 | Register address of the read |
| bus_ack | input | 1 | Read completed, `bus_rdata` valid |
| bus_berr | input | 1 | Read ended in error |
| bus_rdata | input | 32 | Read data |
| force_ack | output | 1 | One-cycle pulse that terminates the internal cycle |

## Verification
A read is tried with a normal acknowledge, with an error, and with a port that never answers before a force command arrives. Comparing the three shows that success, error and cancellation each produce their own response sequence. Stray opcodes shifted during a pending read, and commands placed in the final response slot, show which words are ignored and which are decoded. An unknown opcode followed by a real command shows that the illegal path goes back to idle. The bus model returns address-dependent data in both 16-bit halves, so a swapped or stale half is caught.

// File: rtl/dbg_seq_pkg.sv
package dbg_seq_pkg;
    localparam int WORD_W = 16;
    localparam int LONG_W = 2 * WORD_W;
    localparam int RESP_W = WORD_W + 1;

    localparam logic [WORD_W-1:0] OP_RDCTL = 16'h2980;
    localparam logic [WORD_W-1:0] OP_FORCE = 16'h00C0;

    typedef enum logic [2:0] {
        S_IDLE, S_AHI, S_ALO, S_WAIT, S_MSW, S_FDONE
    } seq_state_e;

    typedef enum logic [1:0] {C_RDCTL, C_FORCE, C_ILLEGAL} cmd_e;

    typedef struct packed {
        logic              status;
        logic [WORD_W-1:0] data;
    } resp_t;

    function automatic resp_t rsp_not_ready();
        return '{status: 1'b1, data: '0};
    endfunction

    function automatic resp_t rsp_fault();
        return '{status: 1'b1, data: WORD_W'(1)};
    endfunction

    function automatic resp_t rsp_complete();
        return '{status: 1'b0, data: '1};
    endfunction

    function automatic resp_t rsp_value(input logic [WORD_W-1:0] v);
        return '{status: 1'b0, data: v};
    endfunction

    function automatic cmd_e classify(input logic [WORD_W-1:0] w);
        if (w == OP_RDCTL) return C_RDCTL;
        if (w == OP_FORCE) return C_FORCE;
        return C_ILLEGAL;
    endfunction
endpackage

// File: rtl/dbg_cmd_decode.sv
module dbg_cmd_decode
    import dbg_seq_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    output cmd_e              cmd
);
    always_comb cmd = classify(word);
endmodule

// File: rtl/dbg_bus_port.sv
module dbg_bus_port
    import dbg_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [LONG_W-1:0] start_addr,
    input  logic              abort,
    input  logic              bus_ack,
    input  logic              bus_berr,
    output logic              bus_req,
    output logic [LONG_W-1:0] bus_addr,
    output logic              done_ok,
    output logic              done_err
);
    always_comb begin
        done_ok  = bus_req & bus_ack;
        done_err = bus_req & bus_berr & ~bus_ack;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_req  <= 1'b0;
            bus_addr <= '0;
        end else if (start) begin
            bus_req  <= 1'b1;
            bus_addr <= start_addr;
        end else if (done_ok || done_err || abort) begin
            bus_req  <= 1'b0;
        end
    end
endmodule

// File: rtl/dbg_resp_pipe.sv
module dbg_resp_pipe
    import dbg_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  resp_t             d,
    input  logic              cap,
    input  logic [WORD_W-1:0] cap_word,
    output logic [WORD_W-1:0] held_word,
    output resp_t             q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q         <= rsp_not_ready();
            held_word <= '0;
        end else begin
            if (load) q <= d;
            if (cap) held_word <= cap_word;
        end
    end
endmodule

// File: rtl/dbg_rdseq.sv
module dbg_rdseq
    import dbg_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              shift_valid,
    input  logic [WORD_W-1:0] shift_word,
    output logic              resp_status,
    output logic [WORD_W-1:0] resp_word,
    output logic              bus_req,
    output logic [LONG_W-1:0] bus_addr,
    input  logic              bus_ack,
    input  logic              bus_berr,
    input  logic [LONG_W-1:0] bus_rdata,
    output logic              force_ack
);
    seq_state_e        st, st_n;
    cmd_e              cmd;
    resp_t             resp_q, resp_d;
    logic              resp_ld, hi_ld, start, abort, force_n, cap;
    logic              done_ok, done_err;
    logic [WORD_W-1:0] addr_hi_q, held_word;

    dbg_cmd_decode u_dec (.word(shift_word), .cmd(cmd));

    dbg_bus_port u_port (
        .clk(clk), .rst(rst), .start(start),
        .start_addr({addr_hi_q, shift_word}), .abort(abort),
        .bus_ack(bus_ack), .bus_berr(bus_berr),
        .bus_req(bus_req), .bus_addr(bus_addr),
        .done_ok(done_ok), .done_err(done_err)
    );

    dbg_resp_pipe u_resp (
        .clk(clk), .rst(rst), .load(resp_ld), .d(resp_d),
        .cap(cap), .cap_word(bus_rdata[WORD_W-1:0]),
        .held_word(held_word), .q(resp_q)
    );

    assign resp_status = resp_q.status;
    assign resp_word   = resp_q.data;

    always_comb begin
        st_n    = st;
        resp_ld = 1'b0;
        resp_d  = resp_q;
        hi_ld   = 1'b0;
        start   = 1'b0;
        abort   = 1'b0;
        force_n = 1'b0;
        cap     = 1'b0;
        unique case (st)
            S_IDLE: if (shift_valid) begin
                resp_ld = 1'b1;
                unique case (cmd)
                    C_RDCTL: begin st_n = S_AHI; resp_d = rsp_not_ready(); end
                    C_FORCE: begin force_n = 1'b1; resp_d = rsp_complete(); end
                    default: resp_d = rsp_fault();
                endcase
            end
            S_AHI: if (shift_valid) begin
                hi_ld = 1'b1; resp_ld = 1'b1;
                resp_d = rsp_not_ready(); st_n = S_ALO;
            end
            S_ALO: if (shift_valid) begin
                start = 1'b1; resp_ld = 1'b1;
                resp_d = rsp_not_ready(); st_n = S_WAIT;
            end
            S_WAIT: begin
                if (done_ok) begin
                    resp_ld = 1'b1; cap = 1'b1;
                    resp_d = rsp_value(bus_rdata[LONG_W-1:WORD_W]);
                    st_n = S_MSW;
                end else if (done_err) begin
                    resp_ld = 1'b1; resp_d = rsp_fault(); st_n = S_IDLE;
                end else if (shift_valid && cmd == C_FORCE) begin
                    abort = 1'b1; force_n = 1'b1; resp_ld = 1'b1;
                    resp_d = rsp_fault(); st_n = S_FDONE;
                end
            end
            S_MSW: if (shift_valid) begin
                resp_ld = 1'b1; resp_d = rsp_value(held_word); st_n = S_IDLE;
            end
            S_FDONE: if (shift_valid) begin
                resp_ld = 1'b1; resp_d = rsp_complete(); st_n = S_IDLE;
            end
            default: st_n = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= S_IDLE;
            addr_hi_q <= '0;
            force_ack <= 1'b0;
        end else begin
            st        <= st_n;
            force_ack <= force_n;
            if (hi_ld) addr_hi_q <= shift_word;
        end
    end
endmodule

// File: rtl/dbg_rdseq_chk.sv
module dbg_rdseq_chk
    import dbg_seq_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              shift_valid,
    input logic [WORD_W-1:0] shift_word,
    input logic              resp_status,
    input logic [WORD_W-1:0] resp_word,
    input logic              bus_req,
    input logic [LONG_W-1:0] bus_addr,
    input logic              bus_ack,
    input logic              bus_berr,
    input logic [LONG_W-1:0] bus_rdata,
    input logic              force_ack
);
    // R5: request held while unanswered and not forced away
    a_r5_req_hold: assert property (@(posedge clk) disable iff (rst)
        bus_req && !bus_ack && !bus_berr && !(shift_valid && shift_word == OP_FORCE)
        |=> bus_req);

    // R5: request drops after an answer
    a_r5_req_drop: assert property (@(posedge clk) disable iff (rst)
        bus_req && (bus_ack || bus_berr) |=> !bus_req);

    // R2: address stable during the request
    a_r2_addr_stable: assert property (@(posedge clk) disable iff (rst)
        bus_req && $past(bus_req) |-> $stable(bus_addr));

    // R3: pending read always shows not-ready
    a_r3_pending_nr: assert property (@(posedge clk) disable iff (rst)
        bus_req |-> resp_status && resp_word == '0);

    // R4: acknowledge loads the upper half
    a_r4_ack_msw: assert property (@(posedge clk) disable iff (rst)
        bus_req && bus_ack |=> !resp_status && resp_word == $past(bus_rdata[LONG_W-1:WORD_W]));

    // R6: error loads the bus-error code
    a_r6_berr_code: assert property (@(posedge clk) disable iff (rst)
        bus_req && bus_berr && !bus_ack |=> resp_status && resp_word == WORD_W'(1));

    // R7: force pulse only after a force opcode shift
    a_r7_force_src: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) && force_ack |-> $past(shift_valid && shift_word == OP_FORCE));
endmodule

bind dbg_rdseq dbg_rdseq_chk u_chk (
    .clk(clk), .rst(rst), .shift_valid(shift_valid), .shift_word(shift_word),
    .resp_status(resp_status), .resp_word(resp_word), .bus_req(bus_req),
    .bus_addr(bus_addr), .bus_ack(bus_ack), .bus_berr(bus_berr),
    .bus_rdata(bus_rdata), .force_ack(force_ack)
);

// File: tb/sim_dbg_rdseq.sv
module sim_dbg_rdseq;
    logic        clk = 1'b0, rst = 1'b1;
    logic        shift_valid = 1'b0;
    logic [15:0] shift_word = '0;
    logic        resp_status, bus_req, force_ack;
    logic [15:0] resp_word;
    logic [31:0] bus_addr;
    logic        bus_ack = 1'b0, bus_berr = 1'b0;
    logic [31:0] bus_rdata = '0;

    int n_total = 0, n_fail = 0;
    int lat = 5, cnt = 0;
    bit berr_mode = 0, hang = 0;

    localparam logic [16:0] NR   = {1'b1, 16'h0000};
    localparam logic [16:0] BAD  = {1'b1, 16'h0001};
    localparam logic [16:0] DONE = {1'b0, 16'hFFFF};
    localparam logic [15:0] RD   = 16'h2980;
    localparam logic [15:0] FRC  = 16'h00C0;

    always #4 clk = ~clk;

    dbg_rdseq u0 (
        .clk(clk), .rst(rst), .shift_valid(shift_valid), .shift_word(shift_word),
        .resp_status(resp_status), .resp_word(resp_word), .bus_req(bus_req),
        .bus_addr(bus_addr), .bus_ack(bus_ack), .bus_berr(bus_berr),
        .bus_rdata(bus_rdata), .force_ack(force_ack)
    );

    function automatic logic [31:0] reg_val(input logic [31:0] a);
        return {a[11:0], 4'h5, ~a[11:0], 4'hA};
    endfunction

    // register model on the internal port
    always @(negedge clk) begin
        bus_ack  = 1'b0;
        bus_berr = 1'b0;
        if (bus_req && !hang) begin
            if (cnt == lat) begin
                if (berr_mode) bus_berr = 1'b1;
                else begin bus_ack = 1'b1; bus_rdata = reg_val(bus_addr); end
                cnt = 0;
            end else cnt = cnt + 1;
        end else cnt = 0;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_total++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic shift(input logic [15:0] w, output logic [16:0] r);
        @(negedge clk);
        r = {resp_status, resp_word};
        shift_valid = 1'b1;
        shift_word  = w;
        @(negedge clk);
        shift_valid = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 50 && bus_req; i++) @(negedge clk);
    endtask

    task automatic start_read(input logic [15:0] hi, input logic [15:0] lo);
        logic [16:0] r;
        shift(RD, r);
        shift(hi, r);  check("R3 nr after opcode", 32'(r), 32'(NR));
        shift(lo, r);  check("R3 nr after addr hi", 32'(r), 32'(NR));
        check("R2 req raised", 32'(bus_req), 1);
        check("R2 address", bus_addr, {hi, lo});
    endtask

    task automatic t_reset();
        check("R1 reset resp", 32'({resp_status, resp_word}), 32'(NR));
        check("R1 reset req", 32'(bus_req), 0);
        check("R1 reset force", 32'(force_ack), 0);
    endtask

    task automatic t_read();
        logic [16:0] r;
        logic [31:0] v;
        berr_mode = 0; hang = 0; lat = 5;
        start_read(16'h0000, 16'h0C04);
        v = reg_val(32'h0000_0C04);
        shift(RD, r);  check("R3 nr after addr lo", 32'(r), 32'(NR));
        check("R5 req held while pending", 32'(bus_req), 1);
        wait_idle();
        check("R5 req dropped", 32'(bus_req), 0);
        shift(16'h1111, r); check("R3 ignored word, R4 msw", 32'(r), 32'({1'b0, v[31:16]}));
        shift(FRC, r); check("R4 lsw", 32'(r), 32'({1'b0, v[15:0]}));
        check("R10 lsw slot cmd force pulse", 32'(force_ack), 1);
        shift(16'h0000, r); check("R10 lsw slot cmd decoded", 32'(r), 32'(DONE));
    endtask

    task automatic t_berr();
        logic [16:0] r;
        berr_mode = 1; hang = 0; lat = 2;
        start_read(16'h0000, 16'h0801);
        wait_idle();
        check("R5 req dropped on berr", 32'(bus_req), 0);
        shift(FRC, r); check("R6 berr response", 32'(r), 32'(BAD));
        shift(16'h0000, r); check("R6 next cmd after berr", 32'(r), 32'(DONE));
        berr_mode = 0;
    endtask

    task automatic t_force_idle();
        logic [16:0] r;
        shift(FRC, r);
        check("R7 force pulse", 32'(force_ack), 1);
        check("R7 no request", 32'(bus_req), 0);
        @(negedge clk);
        check("R7 force one cycle", 32'(force_ack), 0);
        shift(16'h0000, r); check("R7 complete", 32'(r), 32'(DONE));
    endtask

    task automatic t_force_pending();
        logic [16:0] r;
        hang = 1;
        start_read(16'h0000, 16'h0002);
        repeat (3) @(negedge clk);
        check("R5 req held hung", 32'(bus_req), 1);
        shift(FRC, r); check("R3 nr while hung", 32'(r), 32'(NR));
        check("R8 req dropped", 32'(bus_req), 0);
        check("R8 force pulse", 32'(force_ack), 1);
        shift(16'h1234, r); check("R8 berr first", 32'(r), 32'(BAD));
        shift(16'h1234, r); check("R8 complete second", 32'(r), 32'(DONE));
        hang = 0;
    endtask

    task automatic t_illegal();
        logic [16:0] r;
        shift(16'h1234, r);
        shift(RD, r); check("R9 illegal response", 32'(r), 32'(BAD));
        shift(16'h0000, r); check("R9 back to idle, read started", 32'(r), 32'(NR));
        shift(16'h0008, r);
        check("R9 read issued after illegal", 32'(bus_req), 1);
        wait_idle();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_read();
        t_berr();
        t_force_idle();
        t_force_pending();
        t_illegal();
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

    initial begin
        #(8 * 200000);
        n_total++; n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end
endmodule